// File: doc/BRIEF.md
# Memory Protection Region Matcher

The block holds a bank of programmable protection regions and answers, in the same cycle, whether a looked-up address falls inside any enabled region and which region wins. Each region has a base address, a 5-bit size exponent, an enable bit and eight subregion mask bits. A region whose size field holds N spans 2^(N+1) bytes and is aligned to that size. Regions of 256 bytes or more are cut into eight equal slices, and each slice can be masked off on its own.

Software programs the regions indirectly. A region-number register picks the region. Base and size/enable accesses then act on that region only. Every configuration access must be privileged. An unprivileged write changes nothing and raises a one-cycle violation pulse. When the parameter `SPLIT_MAPS` is set, a second bank serves instruction-side lookups and has its own base and size/enable registers.

Top module: `mpu_region_match`

## Requirements
- R1: After reset every region is disabled, `lk_hit_o` is 0, and the region-number, base and size/enable registers all read as zero.
- R2: An enabled region with size field N (1..31) covers the address when the address bits at and above position N+1 equal the base bits at and above that position. The base bits below that position are ignored, so the region spans 2^(N+1) bytes. With N=31 and 32-bit addresses the region covers the whole space.
- R3: A size field of 0 is reserved. Such a region never matches. A privileged write of a size/enable value with bit 0 set and bits [5:1] zero pulses `size_err_o` high for one cycle. The value is still stored.
- R4: Bit 0 of the size/enable register enables the region. While it is 0 the region never matches.
- R5: Bits [15:8] of the size/enable register mask subregions. Bit 8+k masks slice k, the k-th eighth counted from the lowest address. Slice k is selected by address bits [N:N-2]. Masking applies only when N>=7. For smaller regions the bits are stored but have no effect on matching.
- R6: When several regions match, `lk_region_o` reports the highest-numbered one.
- R7: `cfg_sel_i` selects the register: 0 region number, 1 data base, 2 data size/enable, 3 instruction base, 4 instruction size/enable. Codes 5..7 are ignored on write and read as zero. The base and size/enable selects act on the region named by the region-number register.
- R8: If the region-number register holds a value at or above `NUM_REGIONS`, a privileged base or size/enable access changes no region and reads zero, and `cfg_err_o` pulses for one cycle.
- R9: An unprivileged write changes no register and pulses `cfg_viol_o` for one cycle. An unprivileged read returns zero.
- R10: With `SPLIT_MAPS`=1, lookups with `lk_instr_i`=1 use the instruction bank and all other lookups use the data bank. With `SPLIT_MAPS`=0, every lookup uses the data bank, and selects 3 and 4 behave like unused codes.
- R11: A size/enable read returns the stored bits [15:8], [5:1] and [0]. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configuration access strobe |
| cfg_write_i | input | 1 | 1 = write, 0 = read |
| cfg_priv_i | input | 1 | Access is privileged |
| cfg_sel_i | input | 3 | Register select code |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, combinational, zero unless a privileged read is in progress |
| cfg_err_o | output | 1 | Pulse: region access with out-of-range region number |
| cfg_viol_o | output | 1 | Pulse: unprivileged write |
| size_err_o | output | 1 | Pulse: region enabled with reserved size |
| lk_addr_i | input | ADDR_W | Lookup address |
| lk_instr_i | input | 1 | Lookup uses the instruction bank |
| lk_hit_o | output | 1 | Some enabled region covers the address |
| lk_region_o | output | IDX_W | Winning region number |

## Verification
Directed lookups probe the edges of a single region. They check the last byte inside the region against the first byte past it, one masked slice against its neighbours, and the same mask on a 128-byte region where it must have no effect. This separates the size decode from the slice decode. Overlapping regions show whether the priority picks the highest-numbered match rather than the first one. A lookup repeated with the bank select flipped shows whether the two banks are kept apart. A fixed-seed random mix then runs. It writes privileged and unprivileged values into every select, with region numbers beyond the bank and reserved sizes mixed in. The resulting overlapping small regions in a 128 KiB window are looked up, and each outcome is compared with a bench model. This catches stray writes, wrong pulses and mask slips that the directed cases do not reach.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef struct packed {
    logic [7:0] srd;   // subregion disable, bit k = slice k
    logic [4:0] size;  // region spans 2^(size+1) bytes
    logic       en;
  } rgn_cfg_t;

  typedef enum logic [2:0] {
    SEL_RNR   = 3'd0,
    SEL_DBASE = 3'd1,
    SEL_DSIZE = 3'd2,
    SEL_IBASE = 3'd3,
    SEL_ISIZE = 3'd4
  } cfg_sel_e;

  localparam int unsigned SUB_MIN_SIZE = 7;  // size field from which slices apply

  function automatic rgn_cfg_t unpack_cfg(logic [31:0] w);
    rgn_cfg_t c;
    c.srd  = w[15:8];
    c.size = w[5:1];
    c.en   = w[0];
    return c;
  endfunction

  function automatic logic [31:0] pack_cfg(rgn_cfg_t c);
    return {16'h0, c.srd, 2'b00, c.size, c.en};
  endfunction

endpackage

// File: rtl/mpu_reg_bank.sv
module mpu_reg_bank
  import mpu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] base_wdata_i,
  input  rgn_cfg_t          cfg_wdata_i,
  output logic [ADDR_W-1:0] base_o [NUM_REGIONS],
  output rgn_cfg_t          cfg_o  [NUM_REGIONS]
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    logic sel;
    assign sel = (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[g] <= '0;
        cfg_o[g]  <= '0;
      end else begin
        if (base_we_i && sel) base_o[g] <= base_wdata_i;
        if (cfg_we_i && sel)  cfg_o[g]  <= cfg_wdata_i;
      end
    end
  end

endmodule

// File: rtl/mpu_region_cmp.sv
module mpu_region_cmp
  import mpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  rgn_cfg_t          cfg_i,
  output logic              match_o
);

  logic [5:0]        size_log;
  logic [ADDR_W-1:0] cmp_mask;
  logic [ADDR_W-1:0] sub_bits;
  logic [2:0]        sub_idx;
  logic              sub_on;
  logic              upper_eq;

  assign size_log = {1'b0, cfg_i.size} + 6'd1;

  always_comb begin
    for (int b = 0; b < ADDR_W; b++) cmp_mask[b] = (b >= int'(size_log));
  end

  assign upper_eq = (((addr_i ^ base_i) & cmp_mask) == '0);
  assign sub_on   = (cfg_i.size >= 5'(SUB_MIN_SIZE));
  assign sub_bits = addr_i >> (size_log - 6'd3);
  assign sub_idx  = sub_bits[2:0];

  assign match_o = cfg_i.en && (cfg_i.size != 5'd0) && upper_eq &&
                   !(sub_on && cfg_i.srd[sub_idx]);

endmodule

// File: rtl/mpu_prio_pick.sv
module mpu_prio_pick #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned IDX_W       = 3
) (
  input  logic [NUM_REGIONS-1:0] match_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o
);

  // ascending scan: last (highest) match wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (match_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned RNR_W       = 8,
  parameter bit          SPLIT_MAPS  = 1'b1,
  localparam int unsigned IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic              cfg_write_i,
  input  logic              cfg_priv_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_err_o,
  output logic              cfg_viol_o,
  output logic              size_err_o,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              lk_instr_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_region_o
);

  logic [RNR_W-1:0]  rnr_q;
  logic              rnr_ok;
  logic [IDX_W-1:0]  idx;
  logic              wr_ok;
  logic              rd_ok;
  logic              sel_d;
  logic              sel_i;
  logic              bank_sel;
  logic              is_size_sel;

  logic [ADDR_W-1:0] d_base [NUM_REGIONS];
  rgn_cfg_t          d_cfg  [NUM_REGIONS];
  logic [ADDR_W-1:0] i_base [NUM_REGIONS];
  rgn_cfg_t          i_cfg  [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] match;

  assign rnr_ok   = (32'(rnr_q) < NUM_REGIONS);
  assign idx      = rnr_q[IDX_W-1:0];
  assign wr_ok    = cfg_valid_i && cfg_write_i && cfg_priv_i;
  assign rd_ok    = cfg_valid_i && !cfg_write_i && cfg_priv_i;
  assign sel_d    = (cfg_sel_i == SEL_DBASE) || (cfg_sel_i == SEL_DSIZE);
  assign sel_i    = SPLIT_MAPS && ((cfg_sel_i == SEL_IBASE) || (cfg_sel_i == SEL_ISIZE));
  assign bank_sel = sel_d || sel_i;
  assign is_size_sel = (cfg_sel_i == SEL_DSIZE) || (sel_i && cfg_sel_i == SEL_ISIZE);

  // region-number register and pulse flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnr_q      <= '0;
      cfg_err_o  <= 1'b0;
      cfg_viol_o <= 1'b0;
      size_err_o <= 1'b0;
    end else begin
      if (wr_ok && cfg_sel_i == SEL_RNR) rnr_q <= cfg_wdata_i[RNR_W-1:0];
      cfg_err_o  <= cfg_valid_i && cfg_priv_i && bank_sel && !rnr_ok;
      cfg_viol_o <= cfg_valid_i && cfg_write_i && !cfg_priv_i;
      size_err_o <= wr_ok && rnr_ok && is_size_sel &&
                    cfg_wdata_i[0] && (cfg_wdata_i[5:1] == 5'd0);
    end
  end

  mpu_reg_bank #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_dbank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_we_i   (wr_ok && rnr_ok && cfg_sel_i == SEL_DBASE),
    .cfg_we_i    (wr_ok && rnr_ok && cfg_sel_i == SEL_DSIZE),
    .idx_i       (idx),
    .base_wdata_i(cfg_wdata_i[ADDR_W-1:0]),
    .cfg_wdata_i (unpack_cfg(cfg_wdata_i)),
    .base_o      (d_base),
    .cfg_o       (d_cfg)
  );

  if (SPLIT_MAPS) begin : g_ibank
    mpu_reg_bank #(
      .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_ibank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .base_we_i   (wr_ok && rnr_ok && cfg_sel_i == SEL_IBASE),
      .cfg_we_i    (wr_ok && rnr_ok && cfg_sel_i == SEL_ISIZE),
      .idx_i       (idx),
      .base_wdata_i(cfg_wdata_i[ADDR_W-1:0]),
      .cfg_wdata_i (unpack_cfg(cfg_wdata_i)),
      .base_o      (i_base),
      .cfg_o       (i_cfg)
    );
  end else begin : g_no_ibank
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_tie
      assign i_base[g] = '0;
      assign i_cfg[g]  = '0;
    end
  end

  // read path
  always_comb begin
    cfg_rdata_o = '0;
    if (rd_ok) begin
      if (cfg_sel_i == SEL_RNR) begin
        cfg_rdata_o = 32'(rnr_q);
      end else if (bank_sel && rnr_ok) begin
        case (cfg_sel_i)
          SEL_DBASE: cfg_rdata_o = 32'(d_base[idx]);
          SEL_DSIZE: cfg_rdata_o = pack_cfg(d_cfg[idx]);
          SEL_IBASE: cfg_rdata_o = 32'(i_base[idx]);
          SEL_ISIZE: cfg_rdata_o = pack_cfg(i_cfg[idx]);
          default:   cfg_rdata_o = '0;
        endcase
      end
    end
  end

  // lookup path
  logic use_i;
  assign use_i = SPLIT_MAPS && lk_instr_i;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    mpu_region_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .addr_i (lk_addr_i),
      .base_i (use_i ? i_base[g] : d_base[g]),
      .cfg_i  (use_i ? i_cfg[g]  : d_cfg[g]),
      .match_o(match[g])
    );
  end

  mpu_prio_pick #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
    .match_i(match),
    .hit_o  (lk_hit_o),
    .idx_o  (lk_region_o)
  );

endmodule

// File: rtl/mpu_region_match_chk.sv
module mpu_region_match_chk #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned RNR_W       = 8,
  parameter int unsigned IDX_W       = 3,
  parameter bit          SPLIT_MAPS  = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_valid_i,
  input logic             cfg_write_i,
  input logic             cfg_priv_i,
  input logic [2:0]       cfg_sel_i,
  input logic [31:0]      cfg_rdata_o,
  input logic             cfg_err_o,
  input logic             cfg_viol_o,
  input logic             lk_hit_o,
  input logic [IDX_W-1:0] lk_region_o,
  input logic [RNR_W-1:0] rnr_q
);

  logic bank_code;
  logic rnr_bad;
  assign bank_code = (cfg_sel_i == 3'd1) || (cfg_sel_i == 3'd2) ||
                     (SPLIT_MAPS && ((cfg_sel_i == 3'd3) || (cfg_sel_i == 3'd4)));
  assign rnr_bad = (32'(rnr_q) >= NUM_REGIONS);

  // R9
  viol_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_write_i && !cfg_priv_i |=> cfg_viol_o);

  // R9
  unpriv_rnr_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_write_i && !cfg_priv_i |=> $stable(rnr_q));

  // R9
  unpriv_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && !cfg_priv_i |-> cfg_rdata_o == 32'd0);

  // R8
  bad_rnr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_priv_i && bank_code && rnr_bad |=> cfg_err_o);

  // R8
  bad_rnr_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && !cfg_write_i && bank_code && rnr_bad |-> cfg_rdata_o == 32'd0);

  // R8
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(cfg_valid_i && cfg_priv_i));

  // R6
  region_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> 32'(lk_region_o) < NUM_REGIONS);

endmodule

bind mpu_region_match mpu_region_match_chk #(
  .NUM_REGIONS(NUM_REGIONS), .RNR_W(RNR_W), .IDX_W(IDX_W), .SPLIT_MAPS(SPLIT_MAPS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_valid_i (cfg_valid_i),
  .cfg_write_i (cfg_write_i),
  .cfg_priv_i  (cfg_priv_i),
  .cfg_sel_i   (cfg_sel_i),
  .cfg_rdata_o (cfg_rdata_o),
  .cfg_err_o   (cfg_err_o),
  .cfg_viol_o  (cfg_viol_o),
  .lk_hit_o    (lk_hit_o),
  .lk_region_o (lk_region_o),
  .rnr_q       (rnr_q)
);

// File: tb/mpu_region_match_tb.sv
`timescale 1ns/1ps
module mpu_region_match_tb;

  localparam int NREG = 8;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        cfg_valid_i = 0, cfg_write_i = 0, cfg_priv_i = 0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        cfg_err_o, cfg_viol_o, size_err_o;
  logic [31:0] lk_addr_i = '0;
  logic        lk_instr_i = 0;
  logic        lk_hit_o;
  logic [2:0]  lk_region_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mpu_region_match u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_valid_i(cfg_valid_i), .cfg_write_i(cfg_write_i), .cfg_priv_i(cfg_priv_i),
    .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .cfg_err_o(cfg_err_o), .cfg_viol_o(cfg_viol_o), .size_err_o(size_err_o),
    .lk_addr_i(lk_addr_i), .lk_instr_i(lk_instr_i),
    .lk_hit_o(lk_hit_o), .lk_region_o(lk_region_o)
  );

  // bench model
  logic [31:0] m_dbase [NREG];
  logic [31:0] m_dcfg  [NREG];
  logic [31:0] m_ibase [NREG];
  logic [31:0] m_icfg  [NREG];
  logic [7:0]  m_rnr;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit rgn_hit(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    int n, lg, sub;
    if (!c[0]) return 0;
    n = int'(c[5:1]);
    if (n == 0) return 0;
    lg = n + 1;
    if (lg < 32 && ((a >> lg) != (b >> lg))) return 0;
    if (n >= 7) begin
      sub = int'((a >> (lg - 3)) & 32'd7);
      if (c[8 + sub]) return 0;
    end
    return 1;
  endfunction

  task automatic ref_lk(input logic [31:0] a, input bit instr, output bit h, output int r);
    h = 0; r = 0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (instr ? rgn_hit(a, m_ibase[i], m_icfg[i]) : rgn_hit(a, m_dbase[i], m_dcfg[i])) begin
        h = 1; r = i; break;
      end
    end
  endtask

  function automatic logic [31:0] exp_rd(input bit priv, input logic [2:0] sel);
    if (!priv) return 0;
    if (sel == 0) return {24'h0, m_rnr};
    if (sel > 4 || m_rnr >= NREG) return 0;
    case (sel)
      3'd1: return m_dbase[m_rnr[2:0]];
      3'd2: return m_dcfg[m_rnr[2:0]];
      3'd3: return m_ibase[m_rnr[2:0]];
      default: return m_icfg[m_rnr[2:0]];
    endcase
  endfunction

  // one access; checks read data and pulse flags against the model, then updates it
  task automatic acc(input bit wr, input bit priv, input logic [2:0] sel, input logic [31:0] d, input string req);
    logic [31:0] rd, erd;
    bit e_err, e_viol, e_serr, bank, ok;
    bank = (sel >= 1 && sel <= 4);
    ok = m_rnr < NREG;
    erd = wr ? 32'h0 : exp_rd(priv, sel);
    e_err  = priv && bank && !ok;
    e_viol = wr && !priv;
    e_serr = wr && priv && ok && (sel == 2 || sel == 4) && d[0] && d[5:1] == 0;
    @(negedge clk);
    cfg_valid_i = 1; cfg_write_i = wr; cfg_priv_i = priv; cfg_sel_i = sel; cfg_wdata_i = d;
    #1 rd = cfg_rdata_o;
    @(negedge clk);
    cfg_valid_i = 0; cfg_write_i = 0; cfg_priv_i = 0;
    #1;
    if (!wr) check(rd == erd, {req, " rdata"}, rd, erd);
    check(cfg_err_o == e_err,   {req, " R8 cfg_err_o"}, 32'(cfg_err_o), 32'(e_err));
    check(cfg_viol_o == e_viol, {req, " R9 cfg_viol_o"}, 32'(cfg_viol_o), 32'(e_viol));
    check(size_err_o == e_serr, {req, " R3 size_err_o"}, 32'(size_err_o), 32'(e_serr));
    if (wr && priv) begin
      if (sel == 0) m_rnr = d[7:0];
      else if (ok) begin
        case (sel)
          3'd1: m_dbase[m_rnr[2:0]] = d;
          3'd2: m_dcfg[m_rnr[2:0]]  = d & 32'h0000FF3F;
          3'd3: m_ibase[m_rnr[2:0]] = d;
          3'd4: m_icfg[m_rnr[2:0]]  = d & 32'h0000FF3F;
          default: ;
        endcase
      end
    end
  endtask

  task automatic lk(input logic [31:0] a, input bit instr, input string req);
    bit h; int r;
    ref_lk(a, instr, h, r);
    @(negedge clk);
    lk_addr_i = a; lk_instr_i = instr;
    #1;
    check(lk_hit_o == h, {req, " hit"}, 32'(lk_hit_o), 32'(h));
    if (h) check(int'(lk_region_o) == r, {req, " region"}, 32'(lk_region_o), 32'(r));
  endtask

  task automatic set_rgn(input int i, input bit instr, input logic [31:0] b, input logic [31:0] c, input string req);
    acc(1, 1, 3'd0, 32'(i), req);
    acc(1, 1, instr ? 3'd3 : 3'd1, b, req);
    acc(1, 1, instr ? 3'd4 : 3'd2, c, req);
  endtask

  function automatic logic [31:0] mk(input int n, input bit en, input logic [7:0] srd);
    return {16'h0, srd, 2'b00, 5'(n), en};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NREG; i++) begin
      m_dbase[i] = 0; m_dcfg[i] = 0; m_ibase[i] = 0; m_icfg[i] = 0;
    end
    m_rnr = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    #1 check(lk_hit_o == 0, "R1 hit after reset", 32'(lk_hit_o), 0);
    acc(0, 1, 3'd0, 0, "R1 rnr read");
    acc(0, 1, 3'd2, 0, "R1 dsize read");
    acc(0, 1, 3'd1, 0, "R1 dbase read");
    lk(32'h0, 0, "R1 lookup zero");

    // R2 256-byte region at 0x1000
    set_rgn(0, 0, 32'h0000_1000, mk(7, 1, 8'h00), "R2 setup");
    lk(32'h0000_10FF, 0, "R2 last byte");
    lk(32'h0000_1100, 0, "R2 past end");
    lk(32'h0000_0FFF, 0, "R2 below base");
    // R5 mask slice 2 (0x1040..0x105F)
    set_rgn(0, 0, 32'h0000_1000, mk(7, 1, 8'h04), "R5 setup");
    lk(32'h0000_1040, 0, "R5 masked slice");
    lk(32'h0000_105F, 0, "R5 masked slice end");
    lk(32'h0000_1060, 0, "R5 next slice");
    lk(32'h0000_103F, 0, "R5 prev slice");
    // R5 128-byte region: mask bits have no effect
    set_rgn(1, 0, 32'h0000_2000, mk(6, 1, 8'hFF), "R5 small setup");
    lk(32'h0000_2000, 0, "R5 small region ignores mask");
    lk(32'h0000_207F, 0, "R5 small region end");
    // R11 readback layout
    acc(1, 1, 3'd2, 32'hFFFF_FFFF, "R11 write all ones");
    acc(0, 1, 3'd2, 0, "R11 readback");
    // R4 enable clear
    acc(1, 1, 3'd2, mk(6, 0, 8'h00), "R4 disable");
    lk(32'h0000_2010, 0, "R4 disabled region");
    // R3 reserved size
    acc(1, 1, 3'd2, mk(0, 1, 8'h00), "R3 reserved size write");
    lk(32'h0000_2000, 0, "R3 reserved size no match");
    // R6 overlap: regions 3 and 5
    set_rgn(3, 0, 32'h0000_8000, mk(11, 1, 8'h00), "R6 setup low");
    set_rgn(5, 0, 32'h0000_8000, mk(9, 1, 8'h00), "R6 setup high");
    lk(32'h0000_8010, 0, "R6 overlap priority");
    lk(32'h0000_8800, 0, "R6 only lower region");
    // R2 whole space
    set_rgn(7, 0, 32'h0, mk(31, 1, 8'h00), "R2 full setup");
    lk(32'hDEAD_BEEF, 0, "R2 whole space");
    acc(1, 1, 3'd2, mk(31, 0, 8'h00), "R2 full off");
    // R10 instruction bank
    set_rgn(2, 1, 32'h0004_0000, mk(11, 1, 8'h00), "R10 setup");
    lk(32'h0004_0100, 1, "R10 instr bank hit");
    lk(32'h0004_0100, 0, "R10 data bank miss");
    // R7 unused select
    acc(1, 1, 3'd6, 32'h1234_5678, "R7 unused sel write");
    acc(0, 1, 3'd6, 0, "R7 unused sel read");
    // R8 out-of-range region number
    acc(1, 1, 3'd0, 32'd8, "R8 set rnr 8");
    acc(1, 1, 3'd2, mk(10, 1, 8'h00), "R8 write ignored");
    acc(0, 1, 3'd1, 0, "R8 read zero");
    lk(32'h0000_8010, 0, "R8 regions unchanged");
    // R9 unprivileged
    acc(1, 0, 3'd0, 32'd1, "R9 unpriv rnr write");
    acc(0, 1, 3'd0, 0, "R9 rnr unchanged");
    acc(0, 0, 3'd0, 0, "R9 unpriv read");

    // random mix
    for (int it = 0; it < 500; it++) begin
      int op = int'($urandom % 100);
      logic [2:0] sel = 3'($urandom % 6);
      logic [31:0] d;
      if (sel == 0) d = $urandom % 10;
      else if (sel == 1 || sel == 3) d = $urandom & 32'h0001_FFF0;
      else if (sel == 2 || sel == 4) begin
        int r = int'($urandom % 16);
        d = mk((r == 0) ? 0 : 2 + (r % 14), ($urandom % 10) != 0,
               (($urandom % 2) == 0) ? 8'h00 : 8'($urandom));
        if (($urandom % 4) == 0) d = d | ($urandom & 32'hFFFF_00C0);
      end else d = $urandom;
      if (op < 70) acc(1, 1, sel, d, "R7 rand priv write");
      else if (op < 80) acc(1, 0, sel, d, "R9 rand unpriv write");
      else acc(0, ($urandom % 4) != 0, sel, 0, "R11 rand read");
      for (int k = 0; k < 3; k++) lk($urandom & 32'h0001_FFFF, 1'($urandom), "R2 R5 R6 R10 rand lookup");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule